// File: doc/BRIEF.md
# Debug Probe and Loopback Output Controller

This block sits between a streaming multiply-accumulate datapath and the chip's 8-bit result output. During the early cycles of each block operation the datapath leaves that output idle. Those cycles are the idle, scale-load and streaming phases, cycles 0 to 36. The controller can fill this window with a live internal byte chosen by a probe selector. These bytes include the accumulator, the per-lane multiplier products, the metadata, the exception flags, the control signals and the sequencer state. In the flush cycle, cycle 35, it instead echoes the configuration that the datapath latched during setup. Outside the window, the datapath's own result byte and output-enable pass through unchanged.

The controller reads the mode bits only in cycle 0, and only while the sequencer is idle. The debug enable and the probe selector are taken again at the start of every block. A loopback request, once seen, latches until reset. In loopback the output carries the XOR of the two input buses, and every bidirectional pin is held as an input. This lets a board test reach all sixteen input pins before any arithmetic is run. Both outputs are registered, so each value appears one clock after the inputs that produce it.

Top module: `dbgport_ctrl`

## Requirements
- R1: While `rst` is high, on each clock `out_byte` and `bidir_oe` become 0x00, and debug mode, the selector and loopback are all cleared.
- R2: A capture cycle is one where `cycle_idx` is 0 and `fsm_state` equals the idle code (0). In a capture cycle, `in_byte[6]` becomes the debug enable and `bidir_in[3:0]` becomes the probe selector. These bits have no effect in any other cycle, including cycle 0 when the sequencer is not idle.
- R3: With debug off and loopback off, `out_byte` is 0x00 for every cycle with `cycle_idx` from 0 to 36.
- R4: With debug on, for window cycles other than 35, `out_byte` carries the probe chosen by the selector. The codes are:
  - 1: `{fsm_state[1:0], cycle_idx[5:0]}`
  - 2: `exc_flags`
  - 3 to 6: accumulator bits [31:24], [23:16], [15:8] and [7:0], in that order
  - 7 and 8: lane 0 product bits [15:8], then [7:0]
  - 9: `ctrl_sig`
  - 10: `lane0_meta`
  - 11 and 12: lane 1 product bits [15:8], then [7:0]
  - 13: `lane1_meta`
  - 0, 14 and 15: 0x00
- R5: With debug on, in cycle 35 `out_byte` is `{cfg_xscale, cfg_packed, cfg_wrap, cfg_rnd[1:0], cfg_fmt[2:0]}`, with bit 7 first.
- R6: The debug enable and the selector that are in use in cycle 0 stay in force for the rest of the block. They can change only at the next capture cycle, where debug can also be switched off.
- R7: `in_byte[5]` high in a capture cycle enters loopback. Loopback then persists across later blocks, whatever bit 5 does afterwards, until reset.
- R8: In loopback, `out_byte` is `in_byte ^ bidir_in` and `bidir_oe` is 0x00 in every cycle. This applies from the capture cycle itself and overrides the debug and normal outputs.
- R9: Without loopback, in cycles where `cycle_idx` is greater than 36, `out_byte` equals `result_byte` and `bidir_oe` equals `dp_oe`. In window cycles, `bidir_oe` equals `dp_oe` as well.
- R10: Both outputs are registered. The value seen after clock edge n is a function of the inputs present just before edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Dedicated input byte (mode bits 6 and 5) |
| bidir_in | input | 8 | Bidirectional input byte (selector in bits 3:0) |
| cycle_idx | input | 6 | Cycle counter within a block operation |
| fsm_state | input | 2 | Sequencer state, 0 = idle |
| acc | input | 32 | Live accumulator |
| lane0_prod | input | 16 | Lane 0 multiplier product |
| lane1_prod | input | 16 | Lane 1 multiplier product |
| lane0_meta | input | 8 | Lane 0 metadata |
| lane1_meta | input | 8 | Lane 1 metadata |
| exc_flags | input | 8 | Exception flags |
| ctrl_sig | input | 8 | Control signals |
| cfg_fmt | input | 3 | Latched element format |
| cfg_rnd | input | 2 | Latched rounding mode |
| cfg_wrap | input | 1 | Latched overflow-wrap flag |
| cfg_packed | input | 1 | Latched packed-mode flag |
| cfg_xscale | input | 1 | Latched extended-scaling enable |
| result_byte | input | 8 | Normal result byte from the datapath |
| dp_oe | input | 8 | Datapath output-enable for the bidirectional pins |
| out_byte | output | 8 | Registered result output |
| bidir_oe | output | 8 | Registered bidirectional output-enable |

## Verification
Some rules are checked by assertions on every cycle:
- loopback never clears once set;
- the debug mode and selector never move outside a capture cycle;
- loopback forces the XOR output and an all-input enable;
- with debug off the window stays quiet;
- outside the window the result byte passes through.

Other behaviour shows only in the bench's scenarios, which compare against a reference model:
- the byte each selector code picks;
- the bit order of the flush-cycle echo;
- that a non-idle cycle 0 is ignored;
- that debug can be dropped at the next block;
- that reset is the only way out of loopback.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    PRB_NONE   = 4'd0,
    PRB_FSM    = 4'd1,
    PRB_EXC    = 4'd2,
    PRB_ACC3   = 4'd3,
    PRB_ACC2   = 4'd4,
    PRB_ACC1   = 4'd5,
    PRB_ACC0   = 4'd6,
    PRB_L0_HI  = 4'd7,
    PRB_L0_LO  = 4'd8,
    PRB_CTRL   = 4'd9,
    PRB_L0_MD  = 4'd10,
    PRB_L1_HI  = 4'd11,
    PRB_L1_LO  = 4'd12,
    PRB_L1_MD  = 4'd13
  } probe_e;

  typedef struct packed {
    logic       xscale;
    logic       packed_md;
    logic       wrap;
    logic [1:0] rnd;
    logic [2:0] fmt;
  } cfg_echo_t;

endpackage

// File: rtl/dbgport_mode.sv
module dbgport_mode #(
  parameter int CYC_W      = 6,
  parameter int STATE_W    = 2,
  parameter int IDLE_STATE = 0,
  parameter int EN_BIT     = 6,
  parameter int LB_BIT     = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [dbgport_pkg::BYTE_W-1:0]  in_byte,
  input  logic [dbgport_pkg::BYTE_W-1:0]  bidir_in,
  input  logic [CYC_W-1:0]                cycle_idx,
  input  logic [STATE_W-1:0]              fsm_state,
  output logic                            en_eff,
  output logic                            lb_eff,
  output logic [dbgport_pkg::SEL_W-1:0]   sel_eff
);
  import dbgport_pkg::*;

  localparam logic [STATE_W-1:0] IDLE_C = STATE_W'(IDLE_STATE);

  logic             cap;
  logic             dbg_q;
  logic             lb_q;
  logic [SEL_W-1:0] sel_q;

  assign cap = (cycle_idx == '0) && (fsm_state == IDLE_C);

  // Effective mode: the capture cycle already uses the live request bits.
  assign en_eff  = cap ? in_byte[EN_BIT] : dbg_q;
  assign sel_eff = cap ? bidir_in[SEL_W-1:0] : sel_q;
  assign lb_eff  = lb_q | (cap & in_byte[LB_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q <= 1'b0;
      sel_q <= '0;
      lb_q  <= 1'b0;
    end else begin
      if (cap) begin
        dbg_q <= in_byte[EN_BIT];
        sel_q <= bidir_in[SEL_W-1:0];
      end
      lb_q <= lb_eff;
    end
  end

  AST_LB_STICKY: assert property (@(posedge clk) disable iff (rst)
    lb_q |=> lb_q); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(dbg_q) && $stable(sel_q))); // R6

endmodule

// File: rtl/dbgport_probe.sv
module dbgport_probe #(
  parameter int ACC_W   = 32,
  parameter int PROD_W  = 16,
  parameter int CYC_W   = 6,
  parameter int STATE_W = 2
) (
  input  logic [dbgport_pkg::SEL_W-1:0]  sel,
  input  logic [CYC_W-1:0]               cycle_idx,
  input  logic [STATE_W-1:0]             fsm_state,
  input  logic [ACC_W-1:0]               acc,
  input  logic [PROD_W-1:0]              lane0_prod,
  input  logic [PROD_W-1:0]              lane1_prod,
  input  logic [dbgport_pkg::BYTE_W-1:0] lane0_meta,
  input  logic [dbgport_pkg::BYTE_W-1:0] lane1_meta,
  input  logic [dbgport_pkg::BYTE_W-1:0] exc_flags,
  input  logic [dbgport_pkg::BYTE_W-1:0] ctrl_sig,
  output logic [dbgport_pkg::BYTE_W-1:0] probe_byte
);
  import dbgport_pkg::*;

  localparam int ACC_BYTES = ACC_W / BYTE_W;

  logic [BYTE_W-1:0] acc_b [ACC_BYTES];
  logic [BYTE_W-1:0] fsm_b;

  // acc_b[0] is the most significant byte.
  for (genvar k = 0; k < ACC_BYTES; k++) begin : g_acc
    assign acc_b[k] = acc[ACC_W-1-k*BYTE_W -: BYTE_W];
  end

  assign fsm_b = BYTE_W'({fsm_state, cycle_idx});

  always_comb begin
    unique case (probe_e'(sel))
      PRB_FSM:   probe_byte = fsm_b;
      PRB_EXC:   probe_byte = exc_flags;
      PRB_ACC3:  probe_byte = acc_b[0];
      PRB_ACC2:  probe_byte = acc_b[1];
      PRB_ACC1:  probe_byte = acc_b[2];
      PRB_ACC0:  probe_byte = acc_b[3];
      PRB_L0_HI: probe_byte = lane0_prod[PROD_W-1 -: BYTE_W];
      PRB_L0_LO: probe_byte = lane0_prod[BYTE_W-1:0];
      PRB_CTRL:  probe_byte = ctrl_sig;
      PRB_L0_MD: probe_byte = lane0_meta;
      PRB_L1_HI: probe_byte = lane1_prod[PROD_W-1 -: BYTE_W];
      PRB_L1_LO: probe_byte = lane1_prod[BYTE_W-1:0];
      PRB_L1_MD: probe_byte = lane1_meta;
      default:   probe_byte = '0;
    endcase
  end

endmodule

// File: rtl/dbgport_ctrl.sv
module dbgport_ctrl #(
  parameter int ACC_W      = 32,
  parameter int PROD_W     = 16,
  parameter int CYC_W      = 6,
  parameter int STATE_W    = 2,
  parameter int IDLE_STATE = 0,
  parameter int FLUSH_CYC  = 35,
  parameter int WIN_LAST   = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         in_byte,
  input  logic [7:0]         bidir_in,
  input  logic [CYC_W-1:0]   cycle_idx,
  input  logic [STATE_W-1:0] fsm_state,
  input  logic [ACC_W-1:0]   acc,
  input  logic [PROD_W-1:0]  lane0_prod,
  input  logic [PROD_W-1:0]  lane1_prod,
  input  logic [7:0]         lane0_meta,
  input  logic [7:0]         lane1_meta,
  input  logic [7:0]         exc_flags,
  input  logic [7:0]         ctrl_sig,
  input  logic [2:0]         cfg_fmt,
  input  logic [1:0]         cfg_rnd,
  input  logic               cfg_wrap,
  input  logic               cfg_packed,
  input  logic               cfg_xscale,
  input  logic [7:0]         result_byte,
  input  logic [7:0]         dp_oe,
  output logic [7:0]         out_byte,
  output logic [7:0]         bidir_oe
);
  import dbgport_pkg::*;

  localparam logic [CYC_W-1:0] FLUSH_C = CYC_W'(FLUSH_CYC);
  localparam logic [CYC_W-1:0] LAST_C  = CYC_W'(WIN_LAST);

  logic              en_eff;
  logic              lb_eff;
  logic [SEL_W-1:0]  sel_eff;
  logic [BYTE_W-1:0] probe_byte;
  logic              in_win;
  cfg_echo_t         echo;
  logic [BYTE_W-1:0] out_d;
  logic [BYTE_W-1:0] oe_d;

  dbgport_mode #(
    .CYC_W(CYC_W), .STATE_W(STATE_W), .IDLE_STATE(IDLE_STATE),
    .EN_BIT(6), .LB_BIT(5)
  ) u_mode (
    .clk(clk), .rst(rst), .in_byte(in_byte), .bidir_in(bidir_in),
    .cycle_idx(cycle_idx), .fsm_state(fsm_state),
    .en_eff(en_eff), .lb_eff(lb_eff), .sel_eff(sel_eff)
  );

  dbgport_probe #(
    .ACC_W(ACC_W), .PROD_W(PROD_W), .CYC_W(CYC_W), .STATE_W(STATE_W)
  ) u_probe (
    .sel(sel_eff), .cycle_idx(cycle_idx), .fsm_state(fsm_state), .acc(acc),
    .lane0_prod(lane0_prod), .lane1_prod(lane1_prod),
    .lane0_meta(lane0_meta), .lane1_meta(lane1_meta),
    .exc_flags(exc_flags), .ctrl_sig(ctrl_sig), .probe_byte(probe_byte)
  );

  assign in_win = (cycle_idx <= LAST_C);

  always_comb begin
    echo.xscale    = cfg_xscale;
    echo.packed_md = cfg_packed;
    echo.wrap      = cfg_wrap;
    echo.rnd       = cfg_rnd;
    echo.fmt       = cfg_fmt;
  end

  // Priority: loopback, then flush echo, then probe, then quiet window, then result.
  always_comb begin
    oe_d = dp_oe;
    if (lb_eff) begin
      out_d = in_byte ^ bidir_in;
      oe_d  = '0;
    end else if (in_win && en_eff && (cycle_idx == FLUSH_C)) begin
      out_d = echo;
    end else if (in_win && en_eff) begin
      out_d = probe_byte;
    end else if (in_win) begin
      out_d = '0;
    end else begin
      out_d = result_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte <= '0;
      bidir_oe <= '0;
    end else begin
      out_byte <= out_d;
      bidir_oe <= oe_d;
    end
  end

  AST_LB_OE_IN: assert property (@(posedge clk) disable iff (rst)
    lb_eff |=> (bidir_oe == 8'h00)); // R8

  AST_LB_XOR: assert property (@(posedge clk) disable iff (rst)
    lb_eff |=> (out_byte == $past(in_byte ^ bidir_in))); // R8

  AST_QUIET_WIN: assert property (@(posedge clk) disable iff (rst)
    (!lb_eff && !en_eff && in_win) |=> (out_byte == 8'h00)); // R3

  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!lb_eff && !in_win) |=> (out_byte == $past(result_byte) && bidir_oe == $past(dp_oe))); // R9

endmodule

// File: tb/dbgport_ctrl_tb.sv
`timescale 1ns/1ps
module dbgport_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  in_byte, bidir_in;
  logic [5:0]  cycle_idx;
  logic [1:0]  fsm_state;
  logic [31:0] acc;
  logic [15:0] lane0_prod, lane1_prod;
  logic [7:0]  lane0_meta, lane1_meta, exc_flags, ctrl_sig;
  logic [2:0]  cfg_fmt;
  logic [1:0]  cfg_rnd;
  logic        cfg_wrap, cfg_packed, cfg_xscale;
  logic [7:0]  result_byte, dp_oe;
  logic [7:0]  out_byte, bidir_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench-side mode model
  bit       m_en = 0;
  bit       m_lb = 0;
  bit [3:0] m_sel = 0;

  always #2.5 clk = ~clk;

  dbgport_ctrl u_dut (
    .clk(clk), .rst(rst), .in_byte(in_byte), .bidir_in(bidir_in),
    .cycle_idx(cycle_idx), .fsm_state(fsm_state), .acc(acc),
    .lane0_prod(lane0_prod), .lane1_prod(lane1_prod),
    .lane0_meta(lane0_meta), .lane1_meta(lane1_meta),
    .exc_flags(exc_flags), .ctrl_sig(ctrl_sig),
    .cfg_fmt(cfg_fmt), .cfg_rnd(cfg_rnd), .cfg_wrap(cfg_wrap),
    .cfg_packed(cfg_packed), .cfg_xscale(cfg_xscale),
    .result_byte(result_byte), .dp_oe(dp_oe),
    .out_byte(out_byte), .bidir_oe(bidir_oe)
  );

  function automatic [7:0] probe_of(input [3:0] s);
    case (s)
      4'd1:  probe_of = {fsm_state, cycle_idx};
      4'd2:  probe_of = exc_flags;
      4'd3:  probe_of = acc[31:24];
      4'd4:  probe_of = acc[23:16];
      4'd5:  probe_of = acc[15:8];
      4'd6:  probe_of = acc[7:0];
      4'd7:  probe_of = lane0_prod[15:8];
      4'd8:  probe_of = lane0_prod[7:0];
      4'd9:  probe_of = ctrl_sig;
      4'd10: probe_of = lane0_meta;
      4'd11: probe_of = lane1_prod[15:8];
      4'd12: probe_of = lane1_prod[7:0];
      4'd13: probe_of = lane1_meta;
      default: probe_of = 8'h00;
    endcase
  endfunction

  task automatic randomize_data();
    acc = $urandom; lane0_prod = 16'($urandom); lane1_prod = 16'($urandom);
    lane0_meta = 8'($urandom); lane1_meta = 8'($urandom);
    exc_flags = 8'($urandom); ctrl_sig = 8'($urandom);
    cfg_fmt = 3'($urandom); cfg_rnd = 2'($urandom); cfg_wrap = 1'($urandom);
    cfg_packed = 1'($urandom); cfg_xscale = 1'($urandom);
    result_byte = 8'($urandom); dp_oe = 8'($urandom);
  endtask

  task automatic chk(input string req, input [7:0] act, input [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One clock with current inputs; check outputs after the edge (R10).
  task automatic step();
    bit       cap, en, lb;
    bit [3:0] sel;
    bit [7:0] eo, eoe;
    string    req;
    cap = (cycle_idx == 0) && (fsm_state == 2'd0);
    en  = cap ? in_byte[6] : m_en;
    sel = cap ? bidir_in[3:0] : m_sel;
    lb  = m_lb | (cap & in_byte[5]);
    eoe = dp_oe;
    if (lb) begin
      eo = in_byte ^ bidir_in; eoe = 8'h00; req = "R8";
    end else if (cycle_idx <= 36 && en && cycle_idx == 35) begin
      eo = {cfg_xscale, cfg_packed, cfg_wrap, cfg_rnd, cfg_fmt}; req = "R5";
    end else if (cycle_idx <= 36 && en) begin
      eo = probe_of(sel); req = cap ? "R2" : "R4/R6";
    end else if (cycle_idx <= 36) begin
      eo = 8'h00; req = "R3";
    end else begin
      eo = result_byte; req = "R9";
    end
    @(posedge clk); #1;
    chk(req, out_byte, eo);
    chk({req, "_oe"}, bidir_oe, eoe);
    if (cap) begin m_en = in_byte[6]; m_sel = bidir_in[3:0]; end
    m_lb = lb;
  endtask

  // Run one block of cycles 0..last; cycle 0 gets the given mode byte/selector.
  task automatic run_block(input [7:0] mode_b, input [3:0] s, input bit idle0, input int last);
    for (int c = 0; c <= last; c++) begin
      randomize_data();
      cycle_idx = 6'(c);
      fsm_state = (c == 0) ? (idle0 ? 2'd0 : 2'd2) : 2'(1 + $urandom_range(0, 2));
      in_byte  = 8'($urandom);
      bidir_in = 8'($urandom);
      in_byte[5] = 1'b0;
      if (c == 0) begin
        in_byte = mode_b;
        bidir_in[3:0] = s;
      end
      step();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    randomize_data();
    in_byte = 8'hFF; bidir_in = 8'hFF; cycle_idx = 0; fsm_state = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", out_byte, 8'h00);
    chk("R1_oe", bidir_oe, 8'h00);
    rst = 1'b0;
    m_en = 0; m_lb = 0; m_sel = 0;

    // R3: debug off, full block past the window
    run_block(8'h00, 4'd3, 1'b1, 40);
    // R4: every selector code with debug on
    for (int s = 0; s < 16; s++) run_block(8'h40, 4'(s), 1'b1, 38);
    // R2: cycle 0 while not idle ignores the request (debug stays on, sel 13)
    run_block(8'h40, 4'd13, 1'b1, 2);
    run_block(8'h00, 4'd2, 1'b0, 37);
    // R6: debug can be dropped at the next block
    run_block(8'h00, 4'd5, 1'b1, 40);
    // random blocks
    for (int b = 0; b < 40; b++)
      run_block({1'b0, 1'($urandom), 6'($urandom)}, 4'($urandom),
                ($urandom_range(0, 4) != 0), $urandom_range(30, 45));
    // R7: enter loopback, stays across blocks with bit 5 low
    run_block(8'h20, 4'd1, 1'b1, 40);
    run_block(8'h40, 4'd3, 1'b1, 40);
    n_tests++;
    if (!m_lb) begin n_fail++; $display("FAIL R7 actual=0 expected=1"); end
    // R1: reset clears loopback
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
    m_en = 0; m_lb = 0; m_sel = 0;
    chk("R1", out_byte, 8'h00);
    run_block(8'h00, 4'd0, 1'b1, 40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule